// File: doc/BRIEF.md
# Multi-Source Heartbeat Supervisor

This block sits in front of a hardware watchdog and decides when the watchdog may be refreshed. Several independent producers each pulse their own heartbeat line when they make progress. Typical producers are a communication handler, a sensor acquisition routine and a control output stage. The block divides time into supervision intervals of a programmable length. It records which producers pulsed during the current interval. At the last cycle of each interval it emits a one-cycle refresh strobe toward the watchdog, but only if every producer selected by the enable mask has checked in. A single busy producer therefore cannot keep the watchdog alive while another producer is stalled.

When an interval closes without a refresh, the enabled producers that stayed silent are ORed into a sticky miss vector. That vector holds its bits until an explicit clear strobe. Supervision runs only while the run input is high. Dropping it parks the block in an idle state.

The control is a three-state machine:
- `ST_IDLE` (run low): the seen flags are held clear and the interval counter is preloaded.
- `ST_COUNT`: heartbeats are gathered while the counter runs down.
- `ST_JUDGE`: the one-cycle interval boundary, where the verdict is given.

Transitions:
- `IDLE->COUNT` when run is high.
- `COUNT->JUDGE` when the counter expires.
- `JUDGE->COUNT` to open the next interval.
- `COUNT->IDLE` and `JUDGE->IDLE` whenever run is low.

Top module: `hb_supervisor`

## Requirements
- R1: After reset, `refresh_o` is 0 and `miss_o` is all zeros.
- R2: `refresh_o` is high only during a boundary cycle, and only when every enabled source pulsed its heartbeat in that interval. It is never high in two consecutive cycles.
- R3: A source whose bit in `src_en_i` is 0 is treated as having reported. It never blocks a refresh and never sets its miss bit.
- R4: One source pulsing in every cycle does not produce a refresh while another enabled source stays silent.
- R5: At a boundary cycle without refresh, each enabled source that did not pulse has its `miss_o` bit set. The bit is visible from the following cycle. A boundary cycle with refresh leaves `miss_o` unchanged.
- R6: `miss_o` bits are sticky. Only a high `miss_clr_i` clears them, in the next cycle. When a clear coincides with a failing boundary, the new misses of that boundary survive the clear.
- R7: With run held high, boundary cycles recur every `max(intv_len_i,2)` cycles. The first boundary is the `max(intv_len_i,2)`-th cycle after the edge at which run was first seen high. The length is sampled when each interval opens.
- R8: A heartbeat arriving during a boundary cycle counts toward the following interval, not the one being judged.
- R9: While `run_i` is low there is no refresh, no miss update, and heartbeats are discarded. A new run starts with no source marked as seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Supervision enable; low parks the block idle |
| hb_i | input | N_SRC | One heartbeat strobe per source |
| src_en_i | input | N_SRC | Mask of sources required for a refresh |
| intv_len_i | input | INTV_W | Interval length in cycles (values below 2 act as 2) |
| miss_clr_i | input | 1 | Clears the sticky miss vector |
| refresh_o | output | 1 | One-cycle refresh strobe toward the watchdog |
| miss_o | output | N_SRC | Sticky vector of sources that missed an interval |

## Verification
The bench builds the block with three sources and a 4-bit interval length. This keeps all eight enable masks and all eight heartbeat patterns small enough to sweep fully, at interval lengths 3 and 5. Short intervals also put the clamped lengths 0 and 1 within reach, along with multi-interval runs. Those runs cover boundary-cycle heartbeats, one permanently busy source, sticky accumulation across alternating miss patterns, and a clear that lands exactly on a failing boundary.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_JUDGE = 2'd2
    } sup_state_e;

    // Number of counting cycles before the boundary, minus one.
    function automatic logic [15:0] preload_of(input logic [15:0] len);
        logic [15:0] eff;
        eff = (len < 16'd2) ? 16'd2 : len;
        return eff - 16'd2;
    endfunction

endpackage

// File: rtl/hb_seen_bank.sv
module hb_seen_bank #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             restart_i,
    input  logic [N_SRC-1:0] hb_i,
    output logic [N_SRC-1:0] seen_o
);

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        logic flag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (clear_i) begin
                flag_q <= 1'b0;
            end else if (restart_i) begin
                flag_q <= hb_i[k];
            end else if (hb_i[k]) begin
                flag_q <= 1'b1;
            end
        end

        assign seen_o[k] = flag_q;

        AST_SEEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (hb_i[k] && !clear_i) |=> seen_o[k]); // R8

        AST_SEEN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i |=> !seen_o[k]); // R9
    end

endmodule

// File: rtl/hb_interval_ctr.sv
module hb_interval_ctr #(
    parameter int INTV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [INTV_W-1:0] len_i,
    output logic              expired_o
);
    import hb_sup_pkg::*;

    localparam int PW = 16;

    logic [INTV_W-1:0] cnt_q;
    logic [PW-1:0]     preload;

    assign preload = preload_of(PW'(len_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= INTV_W'(preload);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && expired_o) |=> expired_o); // R7

endmodule

// File: rtl/hb_miss_reg.sv
module hb_miss_reg #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [N_SRC-1:0] new_miss_i,
    input  logic             clr_i,
    output logic [N_SRC-1:0] miss_o
);

    logic [N_SRC-1:0] miss_q;
    logic [N_SRC-1:0] base;

    assign base = clr_i ? '0 : miss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_q <= '0;
        end else begin
            miss_q <= base | (capture_i ? new_miss_i : '0);
        end
    end

    assign miss_o = miss_q;

    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((miss_o & $past(miss_o)) == $past(miss_o))); // R6

    AST_MISS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !capture_i) |=> (miss_o == '0)); // R6

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor #(
    parameter int N_SRC  = 3,
    parameter int INTV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [N_SRC-1:0]  hb_i,
    input  logic [N_SRC-1:0]  src_en_i,
    input  logic [INTV_W-1:0] intv_len_i,
    input  logic              miss_clr_i,
    output logic              refresh_o,
    output logic [N_SRC-1:0]  miss_o
);
    import hb_sup_pkg::*;

    sup_state_e       state_q, state_d;
    logic             expired;
    logic [N_SRC-1:0] seen;
    logic             all_ok;
    logic             judging;
    logic             ctr_load;
    logic             seen_clear;
    logic [N_SRC-1:0] fresh_miss;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_i) state_d = ST_COUNT;
            ST_COUNT: begin
                if (!run_i)       state_d = ST_IDLE;
                else if (expired) state_d = ST_JUDGE;
            end
            ST_JUDGE: state_d = run_i ? ST_COUNT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        all_ok     = &(seen | ~src_en_i);
        judging    = 1'b0;
        ctr_load   = 1'b0;
        seen_clear = 1'b0;
        refresh_o  = 1'b0;
        fresh_miss = src_en_i & ~seen;
        unique case (state_q)
            ST_IDLE: begin
                ctr_load   = 1'b1;
                seen_clear = 1'b1;
            end
            ST_COUNT: begin
                seen_clear = !run_i;
            end
            ST_JUDGE: begin
                ctr_load   = 1'b1;
                seen_clear = !run_i;
                judging    = run_i;
                refresh_o  = run_i && all_ok;
            end
            default: begin
                ctr_load   = 1'b1;
                seen_clear = 1'b1;
            end
        endcase
    end

    hb_interval_ctr #(.INTV_W(INTV_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ctr_load),
        .len_i     (intv_len_i),
        .expired_o (expired)
    );

    hb_seen_bank #(.N_SRC(N_SRC)) u_seen (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (seen_clear),
        .restart_i (judging),
        .hb_i      (hb_i),
        .seen_o    (seen)
    );

    hb_miss_reg #(.N_SRC(N_SRC)) u_miss (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (judging && !all_ok),
        .new_miss_i (fresh_miss),
        .clr_i      (miss_clr_i),
        .miss_o     (miss_o)
    );

    AST_REFRESH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |=> !refresh_o); // R2

    AST_JUDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE) |=> (state_q != ST_JUDGE)); // R7

    AST_REFRESH_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> $past(run_i)); // R9

    AST_MISS_HOLD_ON_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_o && !miss_clr_i) |=> $stable(miss_o)); // R5

endmodule

// File: tb/hb_supervisor_bench.sv
module hb_supervisor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_i = 1'b0;
    logic [NS-1:0] hb_i = '0;
    logic [NS-1:0] src_en_i = '0;
    logic [IW-1:0] intv_len_i = '0;
    logic          miss_clr_i = 1'b0;
    logic          refresh_o;
    logic [NS-1:0] miss_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_supervisor #(.N_SRC(NS), .INTV_W(IW)) u_hb_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .hb_i       (hb_i),
        .src_en_i   (src_en_i),
        .intv_len_i (intv_len_i),
        .miss_clr_i (miss_clr_i),
        .refresh_o  (refresh_o),
        .miss_o     (miss_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Heartbeat stimulus per cycle index c, interval length L.
    // mode 0: pat in first cycle of each interval, ~pat in odd intervals when alt
    // mode 1: source 0 pulses every cycle
    // mode 2: pat only in boundary cycles
    function automatic logic [NS-1:0] stim(input int mode, input int c, input int L,
                                          input logic [NS-1:0] pat, input bit alt);
        logic [NS-1:0] p;
        p = (alt && ((c / L) % 2 == 1)) ? ~pat : pat;
        case (mode)
            0:       return (c % L == 0) ? p : '0;
            1:       return 3'b001;
            default: return (c % L == L - 1) ? pat : '0;
        endcase
    endfunction

    task automatic run_seq(input logic [NS-1:0] en, input int len, input int mode,
                           input logic [NS-1:0] pat, input bit alt,
                           input int ncyc, input int clr_at);
        int L;
        logic [NS-1:0] seen_m;
        logic [NS-1:0] miss_m;
        logic [NS-1:0] h;
        bit ok;
        bit judge;
        L = (len < 2) ? 2 : len;
        // idle cycle: run low, clear, heartbeats that must be discarded
        @(negedge clk);
        run_i = 1'b0; miss_clr_i = 1'b1; hb_i = '1;
        src_en_i = en; intv_len_i = IW'(len);
        @(posedge clk);
        #1 check("R9 idle no refresh", 8'(refresh_o), 8'h0);
        @(negedge clk);
        check("R6 clear", 8'(miss_o), 8'h0);
        run_i = 1'b1; miss_clr_i = 1'b0; hb_i = '0;
        @(posedge clk);
        seen_m = '0; miss_m = '0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            h = stim(mode, c, L, pat, alt);
            hb_i = h;
            miss_clr_i = (c == clr_at);
            judge = (c % L == L - 1);
            ok = &(seen_m | ~en);
            #1;
            check(judge ? "R2 R3 R4 refresh at boundary" : "R7 no refresh off boundary",
                  8'(refresh_o), 8'(judge && ok));
            check("R5 R6 miss vector", 8'(miss_o), 8'(miss_m));
            if (miss_clr_i) miss_m = '0;
            if (judge) begin
                if (!ok) miss_m = miss_m | (en & ~seen_m);
                seen_m = h;
            end else begin
                seen_m = seen_m | h;
            end
        end
        @(negedge clk);
        hb_i = '0; miss_clr_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset refresh", 8'(refresh_o), 8'h0);
        check("R1 reset miss", 8'(miss_o), 8'h0);
        rst_n = 1'b1;
        // R2 R3 R5: full sweep of masks and patterns, one interval each
        for (int L = 3; L <= 5; L += 2)
            for (int e = 0; e < 8; e++)
                for (int p = 0; p < 8; p++)
                    run_seq(3'(e), L, 0, 3'(p), 1'b0, L + 1, -1);
        // R4: one busy source, others enabled and silent
        run_seq(3'b011, 4, 1, 3'b000, 1'b0, 12, -1);
        run_seq(3'b001, 4, 1, 3'b000, 1'b0, 12, -1);
        // R8: heartbeats only in boundary cycles
        run_seq(3'b101, 4, 2, 3'b101, 1'b0, 12, -1);
        // R6: alternating misses accumulate; clear coinciding with a failing boundary
        run_seq(3'b111, 3, 0, 3'b110, 1'b1, 12, -1);
        run_seq(3'b111, 3, 0, 3'b100, 1'b0, 9, 5);
        // R7: clamped lengths and longer periods
        run_seq(3'b011, 0, 0, 3'b011, 1'b0, 8, -1);
        run_seq(3'b011, 1, 0, 3'b001, 1'b1, 8, -1);
        run_seq(3'b111, 15, 0, 3'b111, 1'b0, 31, -1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule